// File: doc/BRIEF.md
# Configuration Image Loader

This block pushes a stored configuration image into a programmable device through a 16-bit configuration port. After a start pulse it scans the byte-wide image memory for the start marker (byte 0xFF followed by byte 0x20). It checks that the byte count from the marker to the end of the image is even, then runs the device bring-up sequence and streams the payload two bytes per word. The first byte of each pair goes into the upper half of the word.

Each load attempt pulses the local reset, the reload line and the program pin, then polls the device's init flag. The version nibble seen when init arrives selects the write mode. Value 0x5 means every word waits for a ready flag. Any other value inserts a fixed delay before each word. The device must keep init high after every write. Once the last word is written, the loader polls the done flag and, on success, pulses reset and reload once more. A failed attempt restarts the whole sequence from the marker, up to a fixed number of attempts. The final outcome is latched on `ok` or on `err` with a two-bit cause.

Top module: `cfg_image_loader`

## Requirements
- R1: The payload starts at the first byte pair 0xFF, 0x20 in the image (lowest address). If no such pair exists below `img_len`, the loader ends with `err`=1 and `err_code`=0, and it drives no pulse and no write.
- R2: If `img_len` minus the marker offset is odd, the loader ends with `err`=1 and `err_code`=0, and it drives no pulse and no write.
- R3: The words written on `cfg_wdata` with `cfg_wr` are, in order, {byte[m+2k], byte[m+2k+1]}, where m is the marker offset, for k = 0 up to (len-m)/2-1. Each word takes one `cfg_wr` cycle.
- R4: Each attempt drives `lbus_rst`, then `reload`, then `prog`, each high for exactly PULSE_CYC cycles and never two at once. Only then is init awaited.
- R5: Init is sampled at most INIT_TRIES times, POLL_CYC cycles apart, starting in the first waiting cycle. If it never appears, the attempt fails with cause 1.
- R6: When the version nibble equals 0x5 at init, each word waits for `dev_txrdy`, sampled at most RDY_TRIES times. If ready never appears, the attempt fails with cause 2 and that word is not written.
- R7: With any other version nibble, `dev_txrdy` has no effect: each word is written after FIX_DLY cycles.
- R8: If `dev_init` is low in the cycle after a word write, the attempt fails with cause 2.
- R9: After the last word, done is sampled at most DONE_TRIES times; a miss fails the attempt with cause 3. On success, `lbus_rst` and then `reload` pulse again before `ok` rises.
- R10: At most ATTEMPTS (3) attempts are made. Each retry restarts at the reset pulse and at the marker word. The cause of the last failure is reported.
- R11: `busy` is high from the cycle after an accepted start until completion. `ok` and `err` are never both high, and they hold until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (accepted when idle) |
| img_len | input | LEN_W | Image length in bytes |
| img_addr | output | LEN_W | Image memory byte address |
| img_data | input | 8 | Image byte at `img_addr` (same cycle) |
| dev_init | input | 1 | Device reports init |
| dev_txrdy | input | 1 | Device ready for the next word |
| dev_ver | input | 4 | Device version nibble |
| dev_done | input | 1 | Device reports configuration done |
| lbus_rst | output | 1 | Local reset pulse |
| reload | output | 1 | Reload pulse |
| prog | output | 1 | Program-pin pulse |
| cfg_wr | output | 1 | Word write strobe |
| cfg_wdata | output | 16 | Word written to the device |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |
| err_code | output | 2 | Cause: 0 image, 1 init, 2 write/ready, 3 done |

## Verification
A wrong marker offset or a word pointer that fails to rewind shows up on the first `cfg_wr` of an attempt as a wrong word. A misordered or wrongly sized pulse shows up in the first PULSE_CYC windows after the scan ends. A poll counter that is off by one or more becomes visible only at the limit, so the bench places device response times just inside and just outside the poll windows. The result is then seen either as an extra `prog` pulse from a retry or as a different `err_code`. A wrong mode decision shows up as a hang on `dev_txrdy` or as writes that ignore it, and both appear within the first word.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_RST, S_RLD, S_PROG, S_WINIT, S_FHI, S_FLO,
    S_WAITW, S_WRITE, S_CHECK, S_WDONE, S_FRST, S_FRLD, S_OK, S_ERR
  } ld_state_t;

  typedef enum logic [1:0] {
    ERR_IMAGE = 2'd0,
    ERR_INIT  = 2'd1,
    ERR_WRITE = 2'd2,
    ERR_DONE  = 2'd3
  } ld_err_t;

  localparam logic [7:0] MARK_B0 = 8'hFF;
  localparam logic [7:0] MARK_B1 = 8'h20;

  // true when the pair (a,b) is the start marker
  function automatic logic is_mark(input logic [7:0] a, input logic [7:0] b);
    return (a == MARK_B0) && (b == MARK_B1);
  endfunction

  // true when the byte count from off up to len is even
  function automatic logic tail_is_even(input logic [31:0] len, input logic [31:0] off);
    logic [31:0] d;
    d = len - off;
    return ~d[0];
  endfunction

  function automatic logic [15:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_mark_scan.sv
module cfg_mark_scan
  import cfg_loader_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] len,
  input  logic [7:0]       rd_data,
  output logic [LEN_W-1:0] rd_addr,
  output logic             done,
  output logic             found,
  output logic [LEN_W-1:0] offset
);

  logic             run_q;
  logic             pv_q;
  logic [LEN_W-1:0] idx_q;
  logic [7:0]       prev_q;
  logic             at_end;
  logic             hit;

  assign rd_addr = idx_q;
  assign at_end  = run_q && (idx_q >= len);
  assign hit     = run_q && !at_end && pv_q && is_mark(prev_q, rd_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pv_q   <= 1'b0;
      idx_q  <= '0;
      prev_q <= '0;
      done   <= 1'b0;
      found  <= 1'b0;
      offset <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run_q <= 1'b1;
        pv_q  <= 1'b0;
        idx_q <= '0;
        found <= 1'b0;
      end else if (run_q) begin
        if (at_end) begin
          run_q <= 1'b0;
          done  <= 1'b1;
          found <= 1'b0;
        end else if (hit) begin
          run_q  <= 1'b0;
          done   <= 1'b1;
          found  <= 1'b1;
          offset <= idx_q - LEN_W'(1);
        end else begin
          prev_q <= rd_data;
          pv_q   <= 1'b1;
          idx_q  <= idx_q + LEN_W'(1);
        end
      end
    end
  end

  // R1
  mark_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (offset < len));

endmodule

// File: rtl/cfg_poller.sv
module cfg_poller #(
  parameter int INTERVAL = 8,
  parameter int TRY_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [TRY_W-1:0] limit,
  input  logic             cond,
  output logic             hit,
  output logic             expire
);

  localparam int PC_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [PC_W-1:0]  pc_q;
  logic [TRY_W-1:0] tries_q;
  logic             poll_now;
  logic             last_try;

  assign poll_now = en && (pc_q == '0);
  assign last_try = (tries_q == (limit - TRY_W'(1)));
  assign hit      = poll_now && cond;
  assign expire   = poll_now && !cond && last_try;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pc_q    <= '0;
      tries_q <= '0;
    end else if (poll_now && !cond && !last_try) begin
      tries_q <= tries_q + TRY_W'(1);
      pc_q    <= PC_W'(INTERVAL - 1);
    end else if (en && (pc_q != '0)) begin
      pc_q <= pc_q - PC_W'(1);
    end
  end

  // R5
  try_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (tries_q < limit));

endmodule

// File: rtl/cfg_span_timer.sv
module cfg_span_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  // R4
  span_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!load) && ($past(cnt_q) != '0)) |-> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/cfg_image_loader.sv
module cfg_image_loader
  import cfg_loader_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PULSE_CYC  = 4,
  parameter int POLL_CYC   = 8,
  parameter int FIX_DLY    = 6,
  parameter int INIT_TRIES = 50,
  parameter int RDY_TRIES  = 100,
  parameter int DONE_TRIES = 200,
  parameter int ATTEMPTS   = 3,
  parameter int NEW_VER    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  output logic [LEN_W-1:0] img_addr,
  input  logic [7:0]       img_data,
  input  logic             dev_init,
  input  logic             dev_txrdy,
  input  logic [3:0]       dev_ver,
  input  logic             dev_done,
  output logic             lbus_rst,
  output logic             reload,
  output logic             prog,
  output logic             cfg_wr,
  output logic [15:0]      cfg_wdata,
  output logic             busy,
  output logic             ok,
  output logic             err,
  output logic [1:0]       err_code
);

  localparam int TRY_MAX  = int'(max2(max2(INIT_TRIES, RDY_TRIES), DONE_TRIES));
  localparam int TRY_W    = $clog2(TRY_MAX + 1);
  localparam int SPAN_MAX = int'(max2(PULSE_CYC, FIX_DLY));
  localparam int SPAN_W   = $clog2(SPAN_MAX + 1);
  localparam int ATT_W    = (ATTEMPTS > 1) ? $clog2(ATTEMPTS) : 1;
  localparam logic [SPAN_W-1:0] PULSE_LD = SPAN_W'(PULSE_CYC - 1);
  localparam logic [SPAN_W-1:0] FIX_LD   = SPAN_W'(FIX_DLY - 1);
  localparam logic [TRY_W-1:0]  INIT_LIM = TRY_W'(INIT_TRIES);
  localparam logic [TRY_W-1:0]  RDY_LIM  = TRY_W'(RDY_TRIES);
  localparam logic [TRY_W-1:0]  DONE_LIM = TRY_W'(DONE_TRIES);
  localparam logic [3:0]        VER_HS   = 4'(NEW_VER);

  ld_state_t        st_q, st_n;
  logic [ATT_W-1:0] attempt_q;
  logic [LEN_W-1:0] wp_q, base_q, len_q;
  logic [7:0]       hi_q, lo_q;
  logic             new_mode_q;
  logic             ok_q, err_q;
  ld_err_t          code_q;

  // named internal events
  logic             start_acc;
  logic             attempt_fail;
  ld_err_t          fail_code;
  logic             final_try;
  logic             last_word;
  logic             scan_go, scan_done, scan_found, scan_ok;
  logic [LEN_W-1:0] scan_addr, scan_off;
  logic             poll_clr, poll_en, poll_cond, poll_hit, poll_exp;
  logic [TRY_W-1:0] poll_lim;
  logic             span_load, span_zero;
  logic [SPAN_W-1:0] span_val;

  cfg_mark_scan #(.LEN_W(LEN_W)) u_scan (
    .clk(clk), .rst_n(rst_n), .go(scan_go), .len(len_q), .rd_data(img_data),
    .rd_addr(scan_addr), .done(scan_done), .found(scan_found), .offset(scan_off)
  );

  cfg_poller #(.INTERVAL(POLL_CYC), .TRY_W(TRY_W)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .en(poll_en), .limit(poll_lim),
    .cond(poll_cond), .hit(poll_hit), .expire(poll_exp)
  );

  cfg_span_timer #(.W(SPAN_W)) u_span (
    .clk(clk), .rst_n(rst_n), .load(span_load), .val(span_val), .zero(span_zero)
  );

  assign start_acc = start && ((st_q == S_IDLE) || (st_q == S_OK) || (st_q == S_ERR));
  assign scan_ok   = scan_found && tail_is_even(32'(len_q), 32'(scan_off));
  assign final_try = (attempt_q == ATT_W'(ATTEMPTS - 1));
  assign last_word = (({1'b0, wp_q} + (LEN_W+1)'(2)) >= {1'b0, len_q});

  always_comb begin
    st_n         = st_q;
    scan_go      = 1'b0;
    span_load    = 1'b0;
    span_val     = PULSE_LD;
    poll_clr     = 1'b1;
    poll_en      = 1'b0;
    poll_lim     = INIT_LIM;
    poll_cond    = dev_init;
    attempt_fail = 1'b0;
    fail_code    = ERR_INIT;
    case (st_q)
      S_IDLE, S_OK, S_ERR: if (start_acc) begin st_n = S_SCAN; scan_go = 1'b1; end
      S_SCAN: if (scan_done) begin
        if (scan_ok) begin st_n = S_RST; span_load = 1'b1; end
        else st_n = S_ERR;
      end
      S_RST:  if (span_zero) begin st_n = S_RLD; span_load = 1'b1; end
      S_RLD:  if (span_zero) begin st_n = S_PROG; span_load = 1'b1; end
      S_PROG: if (span_zero) st_n = S_WINIT;
      S_WINIT: begin
        poll_clr = 1'b0; poll_en = 1'b1;
        if (poll_hit) st_n = S_FHI;
        else if (poll_exp) begin attempt_fail = 1'b1; fail_code = ERR_INIT; end
      end
      S_FHI: st_n = S_FLO;
      S_FLO: begin
        st_n = S_WAITW;
        if (!new_mode_q) begin span_load = 1'b1; span_val = FIX_LD; end
      end
      S_WAITW: begin
        if (new_mode_q) begin
          poll_clr = 1'b0; poll_en = 1'b1; poll_lim = RDY_LIM; poll_cond = dev_txrdy;
          if (poll_hit) st_n = S_WRITE;
          else if (poll_exp) begin attempt_fail = 1'b1; fail_code = ERR_WRITE; end
        end else if (span_zero) st_n = S_WRITE;
      end
      S_WRITE: st_n = S_CHECK;
      S_CHECK: begin
        if (!dev_init) begin attempt_fail = 1'b1; fail_code = ERR_WRITE; end
        else if (last_word) st_n = S_WDONE;
        else st_n = S_FHI;
      end
      S_WDONE: begin
        poll_clr = 1'b0; poll_en = 1'b1; poll_lim = DONE_LIM; poll_cond = dev_done;
        if (poll_hit) begin st_n = S_FRST; span_load = 1'b1; end
        else if (poll_exp) begin attempt_fail = 1'b1; fail_code = ERR_DONE; end
      end
      S_FRST: if (span_zero) begin st_n = S_FRLD; span_load = 1'b1; end
      S_FRLD: if (span_zero) st_n = S_OK;
      default: st_n = S_IDLE;
    endcase
    if (attempt_fail) begin
      if (final_try) st_n = S_ERR;
      else begin st_n = S_RST; span_load = 1'b1; span_val = PULSE_LD; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= S_IDLE;
      attempt_q  <= '0;
      wp_q       <= '0;
      base_q     <= '0;
      len_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      new_mode_q <= 1'b0;
      ok_q       <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= ERR_IMAGE;
    end else begin
      st_q <= st_n;
      if (start_acc) begin
        ok_q      <= 1'b0;
        err_q     <= 1'b0;
        attempt_q <= '0;
        len_q     <= img_len;
      end
      if ((st_q == S_SCAN) && scan_done) begin
        if (scan_ok) begin base_q <= scan_off; wp_q <= scan_off; end
        else begin err_q <= 1'b1; code_q <= ERR_IMAGE; end
      end
      if ((st_q == S_WINIT) && poll_hit) new_mode_q <= (dev_ver == VER_HS);
      if (st_q == S_FHI) hi_q <= img_data;
      if (st_q == S_FLO) lo_q <= img_data;
      if ((st_q == S_CHECK) && dev_init && !last_word) wp_q <= wp_q + LEN_W'(2);
      if (attempt_fail) begin
        if (final_try) begin err_q <= 1'b1; code_q <= fail_code; end
        else begin attempt_q <= attempt_q + ATT_W'(1); wp_q <= base_q; end
      end
      if ((st_q == S_FRLD) && span_zero) ok_q <= 1'b1;
    end
  end

  always_comb begin
    case (st_q)
      S_SCAN:  img_addr = scan_addr;
      S_FHI:   img_addr = wp_q;
      S_FLO:   img_addr = wp_q + LEN_W'(1);
      default: img_addr = '0;
    endcase
  end

  assign lbus_rst  = (st_q == S_RST) || (st_q == S_FRST);
  assign reload    = (st_q == S_RLD) || (st_q == S_FRLD);
  assign prog      = (st_q == S_PROG);
  assign cfg_wr    = (st_q == S_WRITE);
  assign cfg_wdata = join_bytes(hi_q, lo_q);
  assign busy      = !((st_q == S_IDLE) || (st_q == S_OK) || (st_q == S_ERR));
  assign ok        = ok_q;
  assign err       = err_q;
  assign err_code  = code_q;

  // R4
  pins_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lbus_rst, reload, prog}));
  // R4
  prog_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog) |-> $past(reload));
  // R9
  ok_after_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(reload));
  // R10
  retry_from_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt_fail && !final_try) |=> (lbus_rst && (wp_q == base_q)));
  // R11
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);
  // R3
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> busy);

endmodule

// File: tb/cfg_image_loader_test.sv
module cfg_image_loader_test;

  localparam int LEN_W = 12;
  localparam int PULSE = 4;
  localparam int POLL  = 8;
  localparam int FIXD  = 6;
  localparam int NINIT = 50;
  localparam int NRDY  = 100;
  localparam int NDONE = 200;

  logic        clk, rst_n, start;
  logic [LEN_W-1:0] img_len, img_addr;
  logic [7:0]  img_data;
  logic        dev_init, dev_txrdy, dev_done;
  logic [3:0]  dev_ver;
  logic        lbus_rst, reload, prog, cfg_wr, busy, ok, err;
  logic [15:0] cfg_wdata;
  logic [1:0]  err_code;

  logic [7:0]  mem [0:511];
  logic [15:0] cap [0:511];
  int          ev  [0:63];

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  // model controls
  logic m_clr = 1'b0;
  int   m_init_dly = 3;
  int   m_drop_at = 0;
  bit   m_done_en = 1'b1;
  int   m_nwords = 0;

  // model state
  int   cap_n, ev_n, prog_n, wcount, icnt, rw, lw, pw, pw_bad;
  logic armed, prog_d, rst_d, rld_d;

  assign img_data = (int'(img_addr) < 512) ? mem[img_addr[8:0]] : 8'h00;

  cfg_image_loader #(
    .LEN_W(LEN_W), .PULSE_CYC(PULSE), .POLL_CYC(POLL), .FIX_DLY(FIXD),
    .INIT_TRIES(NINIT), .RDY_TRIES(NRDY), .DONE_TRIES(NDONE), .ATTEMPTS(3), .NEW_VER(5)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .img_len(img_len), .img_addr(img_addr),
    .img_data(img_data), .dev_init(dev_init), .dev_txrdy(dev_txrdy), .dev_ver(dev_ver),
    .dev_done(dev_done), .lbus_rst(lbus_rst), .reload(reload), .prog(prog),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .busy(busy), .ok(ok), .err(err),
    .err_code(err_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // responsive device model
  always @(posedge clk) begin
    prog_d <= prog; rst_d <= lbus_rst; rld_d <= reload;
    if (m_clr) begin
      cap_n <= 0; ev_n <= 0; prog_n <= 0; wcount <= 0; pw_bad <= 0;
      dev_init <= 1'b0; dev_done <= 1'b0; armed <= 1'b0; icnt <= 0;
      rw <= 0; lw <= 0; pw <= 0;
    end else begin
      if (lbus_rst) begin
        dev_init <= 1'b0; dev_done <= 1'b0; wcount <= 0; armed <= 1'b0;
      end else begin
        if (prog_d && !prog) begin
          if (m_init_dly >= 0) begin armed <= 1'b1; icnt <= m_init_dly; end
        end else if (armed) begin
          if (icnt == 0) begin dev_init <= 1'b1; armed <= 1'b0; end
          else icnt <= icnt - 1;
        end
        if (cfg_wr) begin
          if (cap_n < 512) cap[cap_n] <= cfg_wdata;
          cap_n  <= cap_n + 1;
          wcount <= wcount + 1;
          if (prog_n == 1 && m_drop_at > 0 && wcount + 1 == m_drop_at) dev_init <= 1'b0;
          if (m_done_en && wcount + 1 == m_nwords) dev_done <= 1'b1;
        end
      end
      if (lbus_rst && !rst_d && ev_n < 64) begin ev[ev_n] <= 1; ev_n <= ev_n + 1; end
      if (reload && !rld_d && ev_n < 64) begin ev[ev_n] <= 2; ev_n <= ev_n + 1; end
      if (prog && !prog_d) begin
        if (ev_n < 64) begin ev[ev_n] <= 3; ev_n <= ev_n + 1; end
        prog_n <= prog_n + 1;
      end
      if (lbus_rst) rw <= rw + 1; else begin if (rst_d && rw != PULSE) pw_bad <= pw_bad + 1; rw <= 0; end
      if (reload)   lw <= lw + 1; else begin if (rld_d && lw != PULSE) pw_bad <= pw_bad + 1; lw <= 0; end
      if (prog)     pw <= pw + 1; else begin if (prog_d && pw != PULSE) pw_bad <= pw_bad + 1; pw <= 0; end
    end
  end

  task automatic chk(input bit good, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench view of the marker search (scans from the top down, keeps the lowest)
  function automatic int mark_pos(input int len);
    int pos = -1;
    for (int i = len - 2; i >= 0; i--)
      if (mem[i] == 8'hFF && mem[i+1] == 8'h20) pos = i;
    return pos;
  endfunction

  function automatic logic [15:0] exp_word(input int m, input int k);
    logic [15:0] w;
    w[15:8] = mem[m + 2*k];
    w[7:0]  = mem[m + 2*k + 1];
    return w;
  endfunction

  task automatic fill_noise(input int len);
    for (int i = 0; i < len; i++) mem[i] = 8'($urandom_range(0, 31));
  endtask

  task automatic place_mark(input int p);
    mem[p] = 8'hFF; mem[p+1] = 8'h20;
  endtask

  int el;

  task automatic run(input int len, input int restart_at);
    int n;
    m_clr = 1'b1; @(negedge clk); m_clr = 1'b0;
    img_len = LEN_W'(len);
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", int'(busy), 1);
    n = 0;
    while (busy && n < 20000) begin
      @(negedge clk); n++;
      if (n == restart_at) begin start = 1'b1; @(negedge clk); start = 1'b0; n++; end
    end
    el = n;
    chk(n < 20000, "R11", "load completes", n, 20000);
    chk(!(ok && err), "R11", "ok and err exclusive", int'(ok) + int'(err), 1);
  endtask

  task automatic check_words(input string req, input int first, input int m, input int nw);
    int bad = 0;
    for (int k = 0; k < nw; k++) if (cap[first + k] !== exp_word(m, k)) bad++;
    chk(bad == 0, req, "word mismatches", bad, 0);
  endtask

  task automatic check_result(input string req, input bit e_ok, input int e_code);
    chk(ok == e_ok && err == !e_ok, req, "ok flag", int'(ok), int'(e_ok));
    if (!e_ok) chk(int'(err_code) == e_code, req, "err_code", int'(err_code), e_code);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int len, m, nw;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; img_len = '0; dev_ver = 4'd0; dev_txrdy = 1'b0;
    m_clr = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; m_clr = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!busy && !ok && !err && !cfg_wr && !lbus_rst && !reload && !prog,
        "R11", "reset outputs", int'({busy, ok, err, cfg_wr, lbus_rst, reload, prog}), 0);

    // directed success, handshake mode, with a stray start mid-run (R3 R4 R9 R11)
    fill_noise(25); place_mark(5);
    dev_ver = 4'd5; dev_txrdy = 1'b1; m_init_dly = 3; m_done_en = 1'b1; m_nwords = 10; m_drop_at = 0;
    run(25, 40);
    check_result("R9", 1'b1, 0);
    chk(cap_n == 10, "R3", "word count", cap_n, 10);
    check_words("R3", 0, 5, 10);
    chk(ev_n == 5 && ev[0] == 1 && ev[1] == 2 && ev[2] == 3 && ev[3] == 1 && ev[4] == 2,
        "R4", "pulse order", ev_n, 5);
    chk(pw_bad == 0, "R4", "pulse widths", pw_bad, 0);
    chk(prog_n == 1, "R11", "stray start ignored", prog_n, 1);

    // R1 no marker
    fill_noise(20);
    run(20, -1);
    check_result("R1", 1'b0, 0);
    chk(cap_n == 0 && ev_n == 0, "R1", "no activity", cap_n + ev_n, 0);

    // R2 odd tail
    fill_noise(11); place_mark(4);
    run(11, -1);
    check_result("R2", 1'b0, 0);
    chk(cap_n == 0 && ev_n == 0, "R2", "no activity", cap_n + ev_n, 0);

    // R1 first pair wins: FF FF 20 gives marker at 3
    fill_noise(11); mem[2] = 8'hFF; place_mark(3); mem[7] = 8'hFF; mem[8] = 8'h20;
    m_nwords = 4;
    run(11, -1);
    check_result("R1", 1'b1, 0);
    chk(cap_n == 4 && cap[0] == 16'hFF20, "R1", "first word", int'(cap[0]), 16'hFF20);
    check_words("R1", 0, 3, 4);

    // R5 init never arrives
    fill_noise(12); place_mark(2); m_nwords = 5; m_init_dly = -1;
    run(12, -1);
    check_result("R5", 1'b0, 1);
    chk(prog_n == 3, "R10", "attempts on init timeout", prog_n, 3);
    chk(el >= 3 * (NINIT - 1) * POLL && el <= 3 * (NINIT * POLL + 3 * PULSE) + 100,
        "R5", "init poll span", el, 3 * NINIT * POLL);

    // R5 init just inside the window
    m_init_dly = 45 * POLL;
    run(12, -1);
    check_result("R5", 1'b1, 0);
    chk(prog_n == 1, "R5", "late init single attempt", prog_n, 1);

    // R5 init just outside the window
    m_init_dly = 60 * POLL;
    run(12, -1);
    check_result("R5", 1'b0, 1);

    // R6 handshake mode, ready never comes
    m_init_dly = 3; dev_ver = 4'd5; dev_txrdy = 1'b0;
    run(12, -1);
    check_result("R6", 1'b0, 2);
    chk(cap_n == 0 && prog_n == 3, "R6", "no writes without ready", cap_n, 0);

    // R7 fixed-delay mode ignores ready
    dev_ver = 4'd3; dev_txrdy = 1'b0;
    run(12, -1);
    check_result("R7", 1'b1, 0);
    chk(cap_n == 5, "R7", "word count", cap_n, 5);
    check_words("R7", 0, 2, 5);

    // R8 init drops after third write of attempt 1, retry restarts at marker (R10)
    fill_noise(30); place_mark(6); m_nwords = 12; m_drop_at = 3;
    dev_ver = 4'd5; dev_txrdy = 1'b1;
    run(30, -1);
    check_result("R8", 1'b1, 0);
    chk(prog_n == 2, "R8", "attempts after init drop", prog_n, 2);
    chk(cap_n == 15, "R10", "total writes", cap_n, 15);
    check_words("R10", 0, 6, 3);
    check_words("R10", 3, 6, 12);
    m_drop_at = 0;

    // R9 done never arrives
    m_done_en = 1'b0;
    run(30, -1);
    check_result("R9", 1'b0, 3);
    chk(cap_n == 36 && prog_n == 3, "R10", "writes over 3 attempts", cap_n, 36);
    m_done_en = 1'b1;

    // random images
    for (int it = 0; it < 10; it++) begin
      len = $urandom_range(6, 60);
      for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
      if ($urandom_range(0, 3) != 0) place_mark($urandom_range(0, len - 2));
      dev_ver = ($urandom_range(0, 1) == 1) ? 4'd5 : 4'($urandom_range(0, 4));
      dev_txrdy = (dev_ver == 4'd5) ? 1'b1 : 1'($urandom_range(0, 1));
      m = mark_pos(len);
      nw = (m >= 0) ? (len - m) / 2 : 0;
      m_nwords = nw; m_init_dly = $urandom_range(0, 20);
      run(len, -1);
      if (m < 0 || ((len - m) % 2) != 0) begin
        check_result("R2", 1'b0, 0);
      end else begin
        check_result("R3", 1'b1, 0);
        chk(cap_n == nw, "R3", "random word count", cap_n, nw);
        check_words("R3", 0, m, nw);
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule